// File: doc/BRIEF.md
# DMA Write Completion Handshake

This block decides when a channel's DMA write transfer counts as finished when the data may be landing in remote memory. The DMA engine reports each write transaction to it. A start pulse marks the beginning and carries a channel number and a last-transaction flag. A finish pulse marks the point where the local writes are done. Toward the system the block raises a request while a notified transaction is in flight. It raises a done indication once the local writes are finished. It then holds the transaction until the system returns an acknowledge. Only after that acknowledge, or at once when no handshake applies, does it give the one-cycle transfer-complete pulse for the channel.

Two configuration inputs set the mode, and both are sampled when a transaction starts. When remote-memory support is off, the system handshake is skipped entirely. When it is on, the notify-all input chooses between two policies. In one, every write transaction is handshaked. In the other, only the last transaction of a channel transfer is handshaked. The engine must issue a start only while `txn_ready` is high, and a finish only after its start.

Top module: `dma_wr_handshake`

## Requirements
- R1: After a synchronous active-low reset, `txn_ready` is 1 and `ext_req`, `ext_done` and `xfer_cmpl` are 0.
- R2: With remote-memory support sampled as 0 at the start, `ext_req` and `ext_done` stay 0 for that transaction, and a last transaction raises `xfer_cmpl` in the cycle right after its finish is sampled.
- R3: For a transaction that is handshaked, `ext_req` goes to 1 in the cycle after its start is sampled and stays 1 until the acknowledge is sampled.
- R4: For a handshaked transaction, `ext_done` goes to 1 in the cycle after the finish is sampled and stays 1 until `sys_ack` is sampled. Both `ext_req` and `ext_done` are 0 in the cycle after that, and `xfer_cmpl` stays 0 while the block waits.
- R5: The notify-all input has no effect while remote-memory support is 0.
- R6: With both remote-memory support and notify-all at 1, every transaction is handshaked. A non-last transaction returns to ready after its acknowledge without any `xfer_cmpl` pulse.
- R7: With remote-memory support at 1 and notify-all at 0, only a transaction with the last flag at 1 is handshaked. A non-last transaction produces no request, no done and no `xfer_cmpl`, and `txn_ready` is 1 in the cycle after its finish.
- R8: `ext_chan` and `ext_last` hold the values captured at the start, and they stay unchanged for as long as `ext_req` is 1.
- R9: `xfer_cmpl` is a single-cycle pulse and arrives in the cycle after the acknowledge of a handshaked last transaction. While it is high, `xfer_cmpl_chan` shows that transaction's channel.
- R10: A `sys_ack` sampled while `ext_done` is 0 is ignored. It changes neither `ext_req` nor `xfer_cmpl`.
- R11: `txn_ready` is 0 from the cycle after a start until the transaction has resolved, and it is 0 during the `xfer_cmpl` cycle. Changing the configuration inputs mid-transaction does not alter how that transaction is handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_remote_en | input | 1 | Remote-memory support enable, sampled at start |
| cfg_notify_all | input | 1 | Handshake every transaction (1) or only the last (0), sampled at start |
| wr_start | input | 1 | Pulse: DMA begins a write transaction (honoured while txn_ready is 1) |
| wr_last | input | 1 | Transaction is the last of its channel transfer, valid with wr_start |
| wr_chan | input | CHAN_W | Channel number, valid with wr_start |
| wr_finish | input | 1 | Pulse: local writes of the current transaction are done |
| sys_ack | input | 1 | System acknowledge that the remote writes have landed |
| txn_ready | output | 1 | Block idle, a new start may be issued |
| ext_req | output | 1 | Request toward the system for the current transaction |
| ext_done | output | 1 | Local writes done, waiting for sys_ack |
| ext_last | output | 1 | Last flag of the current transaction |
| ext_chan | output | CHAN_W | Channel of the current transaction |
| xfer_cmpl | output | 1 | One-cycle transfer-complete pulse |
| xfer_cmpl_chan | output | CHAN_W | Channel that completed, valid with xfer_cmpl |

## Verification
The bound checker watches on every cycle for the properties that can be stated locally. A request only appears when the latched mode allows it. Done never appears without the request, and it holds until the acknowledge arrives. The channel and last outputs stay steady while the request is up. The complete pulse lasts one cycle, and a stray acknowledge cannot bring about completion. Other behaviours depend on the whole transaction: the exact cycle of each edge relative to start, finish and acknowledge, the fact that non-last transactions never complete, and the fact that a mid-transaction change of configuration leaves the transaction as it was. Only the bench's scenarios show these. They mix directed corner cases with random mode, channel, last flag, delays and stray acknowledges.

// File: rtl/dwh_pkg.sv
// Package: shared state type for the DMA write completion handshake.
// Assumes: nothing beyond IEEE 1800-2017.
package dwh_pkg;

    // Transaction phase of the handshake controller
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WRITING  = 2'd1,
        ST_WAIT_ACK = 2'd2,
        ST_COMPLETE = 2'd3
    } dwh_state_e;

endpackage

// File: rtl/dwh_policy.sv
// Module: dwh_policy
// Decides whether a starting transaction needs the system handshake.
// Assumes: inputs are the configuration and last flag present with the start
// pulse; the result is combinational and is latched by the caller.
module dwh_policy (
    input  logic remote_en,
    input  logic notify_all,
    input  logic last,
    output logic need_hs
);

    // Handshake only with remote memory, for every write or just the last one
    always_comb begin
        need_hs = remote_en && (notify_all || last);
    end

endmodule

// File: rtl/dwh_tag_reg.sv
// Module: dwh_tag_reg
// Holds the channel, last flag and handshake decision of the transaction
// in flight, captured on an accepted start.
// Assumes: capture is only raised while the controller is idle.
module dwh_tag_reg #(
    parameter int CHAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [CHAN_W-1:0] chan_in,
    input  logic              last_in,
    input  logic              hs_in,
    output logic [CHAN_W-1:0] chan_q,
    output logic              last_q,
    output logic              hs_q
);

    // Capture the transaction tag on an accepted start, otherwise hold it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            last_q <= 1'b0;
            hs_q   <= 1'b0;
        end else if (capture) begin
            chan_q <= chan_in;
            last_q <= last_in;
            hs_q   <= hs_in;
        end
    end

endmodule

// File: rtl/dwh_fsm.sv
// Module: dwh_fsm
// Sequences one write transaction: idle, writing, waiting for the system
// acknowledge, and a one-cycle completion phase.
// Assumes: a finish pulse only comes after its start; the acknowledge is
// only acted on while waiting.
module dwh_fsm
    import dwh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       finish,
    input  logic       ack,
    input  logic       tag_hs,
    input  logic       tag_last,
    output dwh_state_e state
);

    dwh_state_e state_nx;

    // Next-state selection from the current phase and the latched tag
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = ST_WRITING;
            end
            ST_WRITING: begin
                if (finish) begin
                    if (tag_hs)        state_nx = ST_WAIT_ACK;
                    else if (tag_last) state_nx = ST_COMPLETE;
                    else               state_nx = ST_IDLE;
                end
            end
            ST_WAIT_ACK: begin
                if (ack) state_nx = tag_last ? ST_COMPLETE : ST_IDLE;
            end
            ST_COMPLETE: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

endmodule

// File: rtl/dma_wr_handshake.sv
// Module: dma_wr_handshake (top)
// Holds back DMA write completion until the system acknowledges remote
// writes, per transaction or only for the last one, as configured.
// Assumes: the engine issues wr_start only while txn_ready is 1 and one
// wr_finish per start; configuration is sampled at the accepted start.
module dma_wr_handshake
    import dwh_pkg::*;
#(
    parameter int CHAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_remote_en,
    input  logic              cfg_notify_all,
    input  logic              wr_start,
    input  logic              wr_last,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic              wr_finish,
    input  logic              sys_ack,
    output logic              txn_ready,
    output logic              ext_req,
    output logic              ext_done,
    output logic              ext_last,
    output logic [CHAN_W-1:0] ext_chan,
    output logic              xfer_cmpl,
    output logic [CHAN_W-1:0] xfer_cmpl_chan
);

    dwh_state_e        state;
    logic              accept;
    logic              need_hs;
    logic              tag_hs;
    logic              tag_last;
    logic [CHAN_W-1:0] tag_chan;

    // A start is accepted only while idle
    always_comb begin
        accept = wr_start && (state == ST_IDLE);
    end

    dwh_policy u_policy (
        .remote_en  (cfg_remote_en),
        .notify_all (cfg_notify_all),
        .last       (wr_last),
        .need_hs    (need_hs)
    );

    dwh_tag_reg #(.CHAN_W(CHAN_W)) u_tag (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept),
        .chan_in (wr_chan),
        .last_in (wr_last),
        .hs_in   (need_hs),
        .chan_q  (tag_chan),
        .last_q  (tag_last),
        .hs_q    (tag_hs)
    );

    dwh_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .finish   (wr_finish),
        .ack      (sys_ack),
        .tag_hs   (tag_hs),
        .tag_last (tag_last),
        .state    (state)
    );

    // Decode the system-facing and engine-facing outputs from the phase
    always_comb begin
        txn_ready      = (state == ST_IDLE);
        ext_req        = tag_hs && ((state == ST_WRITING) || (state == ST_WAIT_ACK));
        ext_done       = (state == ST_WAIT_ACK);
        ext_last       = tag_last;
        ext_chan       = tag_chan;
        xfer_cmpl      = (state == ST_COMPLETE);
        xfer_cmpl_chan = tag_chan;
    end

endmodule

// File: rtl/dma_wr_handshake_chk.sv
// Module: dma_wr_handshake_chk
// Cycle-by-cycle protocol checks on the handshake ports, bound to the top.
// Assumes: keeps its own shadow of the configuration seen at each accepted
// start so it does not depend on the design's tag register.
module dma_wr_handshake_chk #(
    parameter int CHAN_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_remote_en,
    input logic              cfg_notify_all,
    input logic              wr_start,
    input logic              wr_finish,
    input logic              sys_ack,
    input logic              txn_ready,
    input logic              ext_req,
    input logic              ext_done,
    input logic              ext_last,
    input logic [CHAN_W-1:0] ext_chan,
    input logic              xfer_cmpl
);

    logic sh_remote;
    logic sh_notify;

    // Shadow the mode bits seen at the start the design accepts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_remote <= 1'b0;
            sh_notify <= 1'b0;
        end else if (wr_start && txn_ready) begin
            sh_remote <= cfg_remote_en;
            sh_notify <= cfg_notify_all;
        end
    end

    assert_req_needs_remote_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> sh_remote);

    assert_req_policy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> (sh_notify || ext_last));

    assert_done_with_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_done |-> ext_req);

    assert_done_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_done && !sys_ack) |=> (ext_done && !xfer_cmpl));

    assert_tag_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && $past(ext_req)) |-> ($stable(ext_chan) && $stable(ext_last)));

    assert_cmpl_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_cmpl |=> !xfer_cmpl);

    assert_stray_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_ack && !ext_done && !wr_finish) |=> !xfer_cmpl);

    assert_busy_on_cmpl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_cmpl |-> !txn_ready);

    assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        txn_ready |-> (!ext_req && !ext_done && !xfer_cmpl));

endmodule

bind dma_wr_handshake dma_wr_handshake_chk #(.CHAN_W(CHAN_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_remote_en  (cfg_remote_en),
    .cfg_notify_all (cfg_notify_all),
    .wr_start       (wr_start),
    .wr_finish      (wr_finish),
    .sys_ack        (sys_ack),
    .txn_ready      (txn_ready),
    .ext_req        (ext_req),
    .ext_done       (ext_done),
    .ext_last       (ext_last),
    .ext_chan       (ext_chan),
    .xfer_cmpl      (xfer_cmpl)
);

// File: tb/dma_wr_handshake_tb.sv
// Bench: directed corners plus seeded random transactions, each checked
// against expectations derived from the requirements.
module dma_wr_handshake_tb;

    localparam int CHAN_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_remote_en = 1'b0;
    logic              cfg_notify_all = 1'b0;
    logic              wr_start = 1'b0;
    logic              wr_last = 1'b0;
    logic [CHAN_W-1:0] wr_chan = '0;
    logic              wr_finish = 1'b0;
    logic              sys_ack = 1'b0;
    logic              txn_ready;
    logic              ext_req;
    logic              ext_done;
    logic              ext_last;
    logic [CHAN_W-1:0] ext_chan;
    logic              xfer_cmpl;
    logic [CHAN_W-1:0] xfer_cmpl_chan;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dma_wr_handshake #(.CHAN_W(CHAN_W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_remote_en  (cfg_remote_en),
        .cfg_notify_all (cfg_notify_all),
        .wr_start       (wr_start),
        .wr_last        (wr_last),
        .wr_chan        (wr_chan),
        .wr_finish      (wr_finish),
        .sys_ack        (sys_ack),
        .txn_ready      (txn_ready),
        .ext_req        (ext_req),
        .ext_done       (ext_done),
        .ext_last       (ext_last),
        .ext_chan       (ext_chan),
        .xfer_cmpl      (xfer_cmpl),
        .xfer_cmpl_chan (xfer_cmpl_chan)
    );

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected handshake decision, from the mode requirements
    function automatic bit exp_hs(input bit remote, input bit notify, input bit last);
        return remote && (notify || last);
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    // One full transaction; every check samples at a negedge
    task automatic run_txn(input bit remote, input bit notify, input bit last,
                           input logic [CHAN_W-1:0] chan, input int fin_dly,
                           input int ack_dly, input bit stray, input bit flip_cfg);
        bit hs;
        hs = exp_hs(remote, notify, last);
        chk(txn_ready == 1'b1, "R11 ready before start", txn_ready, 1);
        cfg_remote_en = remote; cfg_notify_all = notify;
        wr_start = 1'b1; wr_last = last; wr_chan = chan;
        step();
        wr_start = 1'b0; wr_last = 1'b0; wr_chan = '0;
        if (flip_cfg) begin cfg_remote_en = ~remote; cfg_notify_all = ~notify; end
        chk(ext_req == hs, "R3 req after start", ext_req, hs);
        chk(txn_ready == 1'b0, "R11 busy after start", txn_ready, 0);
        if (hs) chk(ext_chan == chan && ext_last == last, "R8 tag out", ext_chan, chan);
        if (stray) begin
            sys_ack = 1'b1; step(); sys_ack = 1'b0;
            chk(ext_req == hs && !xfer_cmpl && !txn_ready, "R10 stray ack", ext_req, hs);
        end
        for (int i = 0; i < fin_dly; i++) step();
        wr_finish = 1'b1; step(); wr_finish = 1'b0;
        if (hs) begin
            chk(ext_done == 1'b1 && ext_req == 1'b1, "R4 done after finish", ext_done, 1);
            chk(xfer_cmpl == 1'b0, "R4 no cmpl before ack", xfer_cmpl, 0);
            for (int i = 0; i < ack_dly; i++) begin
                step();
                chk(ext_done && ext_req && !xfer_cmpl, "R4 waiting holds", ext_done, 1);
                chk(ext_chan == chan, "R8 chan stable", ext_chan, chan);
            end
            sys_ack = 1'b1; step(); sys_ack = 1'b0;
            chk(!ext_req && !ext_done, "R4 release after ack", ext_req, 0);
            chk(xfer_cmpl == last, "R6 R9 cmpl after ack", xfer_cmpl, last);
            if (!last) chk(txn_ready == 1'b1, "R6 ready after ack", txn_ready, 1);
        end else begin
            chk(ext_req == 1'b0 && ext_done == 1'b0, "R2 R5 R7 no handshake", ext_done, 0);
            chk(xfer_cmpl == last, "R2 R7 cmpl after finish", xfer_cmpl, last);
            if (!last) chk(txn_ready == 1'b1, "R7 ready after finish", txn_ready, 1);
        end
        if (last) begin
            chk(xfer_cmpl_chan == chan, "R9 cmpl chan", xfer_cmpl_chan, chan);
            chk(txn_ready == 1'b0, "R11 busy in cmpl", txn_ready, 0);
            step();
            chk(xfer_cmpl == 1'b0, "R9 single pulse", xfer_cmpl, 0);
        end
        chk(txn_ready == 1'b1, "R11 ready after resolve", txn_ready, 1);
        step();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) step();
        chk(txn_ready == 1'b1, "R1 ready in reset", txn_ready, 1);
        chk(!ext_req && !ext_done && !xfer_cmpl, "R1 outputs low", ext_req, 0);
        rst_n = 1'b1;
        step();
        chk(txn_ready && !ext_req && !ext_done && !xfer_cmpl, "R1 after reset", txn_ready, 1);
        // R10: stray acknowledge while idle
        sys_ack = 1'b1; step(); sys_ack = 1'b0;
        chk(!xfer_cmpl && !ext_req && txn_ready, "R10 ack while idle", xfer_cmpl, 0);
        // Directed corners
        run_txn(0, 0, 1, 4'h3, 0, 0, 0, 0);   // R2 last, no remote
        run_txn(0, 1, 0, 4'h5, 1, 0, 0, 0);   // R5 notify ignored, non-last
        run_txn(0, 1, 1, 4'h6, 2, 0, 1, 0);   // R5 R10
        run_txn(1, 1, 0, 4'h9, 0, 0, 0, 0);   // R6 non-last handshaked, immediate ack
        run_txn(1, 1, 1, 4'hA, 1, 3, 1, 0);   // R6 last
        run_txn(1, 0, 0, 4'hC, 2, 0, 0, 0);   // R7 non-last skipped
        run_txn(1, 0, 1, 4'hF, 0, 2, 0, 1);   // R7 R11 config flip mid-transaction
        run_txn(0, 0, 1, 4'h1, 0, 0, 0, 1);   // R11 flip to remote has no effect
        // Seeded random transactions
        for (int n = 0; n < 200; n++) begin
            run_txn(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), CHAN_W'($urandom_range(0, 15)),
                    $urandom_range(0, 4), $urandom_range(0, 5),
                    1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0));
        end
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule